// File: doc/BRIEF.md
# Tagged-Extent Block Instruction Splitter

This block takes one fetched code block of the mixed-length mode and finds every instruction boundary inside it in a single cycle. A block is a 32-bit header followed by fourteen 16-bit extents. The header carries a 4-bit mode code and one 2-bit tag per extent. The tags, not opcode bits, say where instructions begin.

For every extent position the block reports one of four kinds:
- a 17-bit short instruction, rebuilt from the tag and the extent;
- the first extent of a long instruction, with its length;
- a continuation extent of a long instruction;
- pseudo-immediate space that holds no instruction.

Long instructions with an illegal length are flagged per slot. All results leave together in one registered descriptor vector, so that downstream decoders can work on every instruction of the block in parallel. Blocks enter and leave through valid/ready handshakes, and one block is taken per cycle while the output side is ready.

Top module: `tes_splitter`

## Requirements
- R1: The header's top 4 bits (`in_hdr[31:28]`) must equal 4'b1111 for the block to be split. For any other value, `out_hdr_bad` is 1 and every mask, length and short value of that result is zero.
- R2: Extent i is `in_ext[16*i+15:16*i]`, and its tag is `in_hdr[2*i+1:2*i]`, for i = 0..13.
- R3: Tag 2'b00 or 2'b01 marks a short instruction. It sets `out_short_mask[i]` and length 1. The 17-bit value in `out_short[17*i+16:17*i]` is the tag's low bit placed above the 16 extent bits.
- R4: Tag 2'b10 sets `out_long_start[i]`. Its length in extents, `out_len[4*i+3:4*i]`, is 1 plus the number of consecutive tag-2'b11 extents directly after it.
- R5: A tag-2'b11 extent whose nearest preceding tag other than 2'b11 is 2'b10 sets `out_cont_mask[i]`.
- R6: A tag-2'b11 extent at the start of the block, or whose nearest preceding tag other than 2'b11 is a short tag, sets `out_pimm_mask[i]` and produces no instruction.
- R7: A long start whose length is below 2 or above 6 extents sets `out_err_mask[i]`. This means below 32 or above 96 bits, and it includes a start in the last extent.
- R8: Slots that are not short report a zero short value. Slots that are neither short nor a long start report length zero.
- R9: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted block appears on the outputs at the next clock edge. The outputs hold steady while `out_valid` is high and `out_ready` is low.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | The block is taken this cycle |
| in_hdr | input | 32 | Mode code and per-extent tags |
| in_ext | input | 224 | Fourteen 16-bit extents |
| out_valid | output | 1 | Descriptor vector is valid |
| out_ready | input | 1 | Consumer takes the descriptor vector |
| out_hdr_bad | output | 1 | Mode code was not 4'b1111 |
| out_long_start | output | 14 | Long instruction starts at the slot |
| out_short_mask | output | 14 | Short instruction at the slot |
| out_pimm_mask | output | 14 | Pseudo-immediate space at the slot |
| out_cont_mask | output | 14 | Continuation of a long instruction |
| out_err_mask | output | 14 | Illegal long length at the slot |
| out_len | output | 56 | Per-slot length in extents, 4 bits each |
| out_short | output | 238 | Per-slot 17-bit short instruction |

## Verification
The assertions assume that `out_ready` is a plain input that the consumer may drop at any time. They also assume that `in_hdr` and `in_ext` need only be stable in the cycle they are accepted, so the hold check relies on the block's own register rather than on steady inputs. Every tag value is legal on the wire. The stimulus therefore covers all four tags in every position: an exhaustive sweep over the first four slots against fixed tails, pseudo-random full blocks, and directed blocks for the length limits, a start in the last slot and bad mode codes. Back-pressure is applied only through `out_ready`, with a second block waiting at the input, so both the hold and the simultaneous drain-and-fill paths are exercised.

// File: rtl/tes_pkg.sv
`timescale 1ns/1ps
package tes_pkg;
    localparam int        CODE_W   = 4;
    localparam logic [3:0] HDR_CODE = 4'b1111;

    typedef enum logic [1:0] {
        TAG_SHORT0 = 2'b00,
        TAG_SHORT1 = 2'b01,
        TAG_LONG   = 2'b10,
        TAG_CONT   = 2'b11
    } tag_e;
endpackage

// File: rtl/tes_tag_scan.sv
`timescale 1ns/1ps
// Scans the tag row in both directions: backward to count trailing
// continuation tags, forward to tell owned continuations from free space.
module tes_tag_scan
    import tes_pkg::*;
#(
    parameter int NUM_EXT = 14,
    parameter int LEN_W   = 4
) (
    input  logic [2*NUM_EXT-1:0]     tags,
    output logic [NUM_EXT-1:0]       cont_mask,
    output logic [NUM_EXT*LEN_W-1:0] tail_run
);
    logic [LEN_W-1:0] run11 [NUM_EXT+1];
    logic             owned [NUM_EXT+1];

    assign run11[NUM_EXT] = '0;
    assign owned[0]       = 1'b0;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_scan
        logic is_cont;
        logic is_long;
        assign is_cont = (tags[2*i +: 2] == TAG_CONT);
        assign is_long = (tags[2*i +: 2] == TAG_LONG);
        // Backward: number of tag-11 extents from position i onward.
        assign run11[i] = is_cont ? (run11[i+1] + LEN_W'(1)) : '0;
        assign tail_run[i*LEN_W +: LEN_W] = run11[i+1];
        // Forward: a long start opens ownership, 11 keeps it, shorts close it.
        assign owned[i+1]   = is_long | (is_cont & owned[i]);
        assign cont_mask[i] = is_cont & owned[i];
    end
endmodule

// File: rtl/tes_slot.sv
`timescale 1ns/1ps
// Classifies one extent position from its tag and the scan results.
module tes_slot
    import tes_pkg::*;
#(
    parameter int EXT_W    = 16,
    parameter int LEN_W    = 4,
    parameter int MIN_LONG = 2,
    parameter int MAX_LONG = 6
) (
    input  logic [1:0]       tag,
    input  logic [EXT_W-1:0] ext,
    input  logic             cont,
    input  logic [LEN_W-1:0] tail_run,
    output logic             is_short,
    output logic             is_long,
    output logic             is_pimm,
    output logic             is_err,
    output logic [LEN_W-1:0] len,
    output logic [EXT_W:0]   short_val
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LONG);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LONG);

    always_comb begin
        is_short  = 1'b0;
        is_long   = 1'b0;
        is_pimm   = 1'b0;
        is_err    = 1'b0;
        len       = '0;
        short_val = '0;
        case (tag_e'(tag))
            TAG_SHORT0, TAG_SHORT1: begin
                is_short  = 1'b1;
                len       = LEN_W'(1);
                short_val = {tag[0], ext};
            end
            TAG_LONG: begin
                is_long = 1'b1;
                len     = tail_run + LEN_W'(1);
                is_err  = (len < MIN_L) || (len > MAX_L);
            end
            default: begin
                is_pimm = !cont;
            end
        endcase
    end
endmodule

// File: rtl/tes_splitter.sv
`timescale 1ns/1ps
// Splits one tagged code block into per-extent descriptors, registered.
module tes_splitter
    import tes_pkg::*;
#(
    parameter int NUM_EXT  = 14,
    parameter int EXT_W    = 16,
    parameter int MIN_LONG = 2,
    parameter int MAX_LONG = 6,
    localparam int LEN_W   = $clog2(NUM_EXT + 1),
    localparam int HDR_W   = CODE_W + 2*NUM_EXT,
    localparam int SHORT_W = EXT_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [HDR_W-1:0]           in_hdr,
    input  logic [NUM_EXT*EXT_W-1:0]   in_ext,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic                       out_hdr_bad,
    output logic [NUM_EXT-1:0]         out_long_start,
    output logic [NUM_EXT-1:0]         out_short_mask,
    output logic [NUM_EXT-1:0]         out_pimm_mask,
    output logic [NUM_EXT-1:0]         out_cont_mask,
    output logic [NUM_EXT-1:0]         out_err_mask,
    output logic [NUM_EXT*LEN_W-1:0]   out_len,
    output logic [NUM_EXT*SHORT_W-1:0] out_short
);
    typedef struct packed {
        logic                       valid;
        logic                       hdr_bad;
        logic [NUM_EXT-1:0]         long_start;
        logic [NUM_EXT-1:0]         short_mask;
        logic [NUM_EXT-1:0]         pimm_mask;
        logic [NUM_EXT-1:0]         cont_mask;
        logic [NUM_EXT-1:0]         err_mask;
        logic [NUM_EXT*LEN_W-1:0]   len;
        logic [NUM_EXT*SHORT_W-1:0] shrt;
    } out_t;

    out_t st_d, st_q;

    logic [NUM_EXT-1:0]         scan_cont;
    logic [NUM_EXT*LEN_W-1:0]   scan_run;
    logic [NUM_EXT-1:0]         s_short, s_long, s_pimm, s_err;
    logic [NUM_EXT*LEN_W-1:0]   s_len;
    logic [NUM_EXT*SHORT_W-1:0] s_shrt;
    logic                       hdr_ok;
    logic                       take;

    tes_tag_scan #(.NUM_EXT(NUM_EXT), .LEN_W(LEN_W)) u_scan (
        .tags      (in_hdr[2*NUM_EXT-1:0]),
        .cont_mask (scan_cont),
        .tail_run  (scan_run)
    );

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_slot
        tes_slot #(
            .EXT_W(EXT_W), .LEN_W(LEN_W),
            .MIN_LONG(MIN_LONG), .MAX_LONG(MAX_LONG)
        ) u_slot (
            .tag       (in_hdr[2*i +: 2]),
            .ext       (in_ext[i*EXT_W +: EXT_W]),
            .cont      (scan_cont[i]),
            .tail_run  (scan_run[i*LEN_W +: LEN_W]),
            .is_short  (s_short[i]),
            .is_long   (s_long[i]),
            .is_pimm   (s_pimm[i]),
            .is_err    (s_err[i]),
            .len       (s_len[i*LEN_W +: LEN_W]),
            .short_val (s_shrt[i*SHORT_W +: SHORT_W])
        );
    end

    assign in_ready = !st_q.valid || out_ready;
    assign take     = in_valid && in_ready;
    assign hdr_ok   = (in_hdr[HDR_W-1 -: CODE_W] == HDR_CODE);

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.valid = 1'b0;
        end
        if (take) begin
            st_d.valid      = 1'b1;
            st_d.hdr_bad    = !hdr_ok;
            st_d.long_start = hdr_ok ? s_long    : '0;
            st_d.short_mask = hdr_ok ? s_short   : '0;
            st_d.pimm_mask  = hdr_ok ? s_pimm    : '0;
            st_d.cont_mask  = hdr_ok ? scan_cont : '0;
            st_d.err_mask   = hdr_ok ? s_err     : '0;
            st_d.len        = hdr_ok ? s_len     : '0;
            st_d.shrt       = hdr_ok ? s_shrt    : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign out_hdr_bad    = st_q.hdr_bad;
    assign out_long_start = st_q.long_start;
    assign out_short_mask = st_q.short_mask;
    assign out_pimm_mask  = st_q.pimm_mask;
    assign out_cont_mask  = st_q.cont_mask;
    assign out_err_mask   = st_q.err_mask;
    assign out_len        = st_q.len;
    assign out_short      = st_q.shrt;
endmodule

// File: rtl/tes_splitter_chk.sv
`timescale 1ns/1ps
module tes_splitter_chk #(
    parameter int NUM_EXT = 14,
    parameter int LEN_W   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic                     out_hdr_bad,
    input logic [NUM_EXT-1:0]       out_long_start,
    input logic [NUM_EXT-1:0]       out_short_mask,
    input logic [NUM_EXT-1:0]       out_pimm_mask,
    input logic [NUM_EXT-1:0]       out_cont_mask,
    input logic [NUM_EXT-1:0]       out_err_mask,
    input logic [NUM_EXT*LEN_W-1:0] out_len
);
    logic [NUM_EXT-1:0] any_kind;
    assign any_kind = out_long_start | out_short_mask | out_pimm_mask | out_cont_mask;

    AST_BAD_HDR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_hdr_bad |-> (any_kind == '0) && (out_err_mask == '0) && (out_len == '0)); // R1

    AST_EVERY_SLOT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hdr_bad |-> (any_kind == '1)); // R3

    AST_KINDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_long_start & out_short_mask) == '0) && ((out_long_start & out_cont_mask) == '0)
                   && ((out_long_start & out_pimm_mask) == '0) && ((out_short_mask & out_cont_mask) == '0)
                   && ((out_short_mask & out_pimm_mask) == '0) && ((out_cont_mask & out_pimm_mask) == '0)); // R6

    AST_CONT_FOLLOWS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_cont_mask & ~((out_long_start | out_cont_mask) << 1)) == '0)); // R5

    AST_ERR_ONLY_ON_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_err_mask & ~out_long_start) == '0)); // R7

    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready)); // R9

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_long_start) && $stable(out_len)
                                   && $stable(out_short_mask) && $stable(out_pimm_mask)); // R9
endmodule

bind tes_splitter tes_splitter_chk #(.NUM_EXT(NUM_EXT), .LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_hdr_bad    (out_hdr_bad),
    .out_long_start (out_long_start),
    .out_short_mask (out_short_mask),
    .out_pimm_mask  (out_pimm_mask),
    .out_cont_mask  (out_cont_mask),
    .out_err_mask   (out_err_mask),
    .out_len        (out_len)
);

// File: tb/sim_tes_splitter.sv
`timescale 1ns/1ps
module sim_tes_splitter;
    localparam int NE = 14;
    localparam int EW = 16;
    localparam int LW = 4;
    localparam int SW = 17;
    localparam int HW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [HW-1:0]   in_hdr = '0;
    logic [NE*EW-1:0] in_ext = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic            out_hdr_bad;
    logic [NE-1:0]   out_long_start, out_short_mask, out_pimm_mask, out_cont_mask, out_err_mask;
    logic [NE*LW-1:0] out_len;
    logic [NE*SW-1:0] out_short;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rng = 32'h1234_5678;

    logic            e_bad;
    logic [NE-1:0]   e_long, e_short, e_pimm, e_cont, e_err;
    logic [NE*LW-1:0] e_len;
    logic [NE*SW-1:0] e_shrt;

    always #5 clk = ~clk;

    tes_splitter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .in_ext(in_ext), .out_valid(out_valid), .out_ready(out_ready),
        .out_hdr_bad(out_hdr_bad), .out_long_start(out_long_start),
        .out_short_mask(out_short_mask), .out_pimm_mask(out_pimm_mask),
        .out_cont_mask(out_cont_mask), .out_err_mask(out_err_mask),
        .out_len(out_len), .out_short(out_short)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference model built directly from the requirement text.
    task automatic model(input logic [HW-1:0] hdr, input logic [NE*EW-1:0] ext);
        e_bad = (hdr[HW-1 -: 4] != 4'b1111);
        e_long = '0; e_short = '0; e_pimm = '0; e_cont = '0; e_err = '0;
        e_len = '0; e_shrt = '0;
        if (!e_bad) begin
            for (int i = 0; i < NE; i++) begin
                logic [1:0] t = hdr[2*i +: 2];
                if (t == 2'b00 || t == 2'b01) begin
                    e_short[i] = 1'b1;
                    e_len[i*LW +: LW] = 4'd1;
                    e_shrt[i*SW +: SW] = {t[0], ext[i*EW +: EW]};
                end else if (t == 2'b10) begin
                    int n = 1;
                    while (i + n < NE && hdr[2*(i+n) +: 2] == 2'b11) begin
                        e_cont[i+n] = 1'b1;
                        n++;
                    end
                    e_long[i] = 1'b1;
                    e_len[i*LW +: LW] = LW'(n);
                    e_err[i] = (n < 2) || (n > 6);
                end else if (!e_cont[i]) begin
                    e_pimm[i] = 1'b1;
                end
            end
        end
    endtask

    task automatic cmp_all(input string tag);
        chk("R1", {tag, " hdr_bad"}, 256'(out_hdr_bad), 256'(e_bad));
        chk("R4", {tag, " long_start"}, 256'(out_long_start), 256'(e_long));
        chk("R3", {tag, " short_mask"}, 256'(out_short_mask), 256'(e_short));
        chk("R6", {tag, " pimm_mask"}, 256'(out_pimm_mask), 256'(e_pimm));
        chk("R5", {tag, " cont_mask"}, 256'(out_cont_mask), 256'(e_cont));
        chk("R7", {tag, " err_mask"}, 256'(out_err_mask), 256'(e_err));
        chk("R8", {tag, " len"}, 256'(out_len), 256'(e_len));
        chk("R2", {tag, " short"}, 256'(out_short), 256'(e_shrt));
    endtask

    function automatic logic [NE*EW-1:0] make_ext(input logic [31:0] seed);
        logic [NE*EW-1:0] v;
        for (int i = 0; i < NE; i++) v[i*EW +: EW] = 16'(seed * 32'd40503 + i * 4099);
        return v;
    endfunction

    task automatic run_block(input logic [HW-1:0] hdr, input logic [NE*EW-1:0] ext, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_hdr = hdr; in_ext = ext;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", {tag, " out_valid"}, 256'(out_valid), 256'(1));
        model(hdr, ext);
        cmp_all(tag);
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [HW-1:0] hA, hB;
        logic [19:0] tails [4];
        tails[0] = 20'h00000; tails[1] = 20'hFFFFF; tails[2] = 20'hFFFFE; tails[3] = 20'h9C6D2;

        repeat (3) @(negedge clk);
        chk("R10", "reset out_valid", 256'(out_valid), 256'(0));
        chk("R10", "reset in_ready", 256'(in_ready), 256'(1));
        rst_n = 1'b1;

        // Exhaustive first four slots against fixed tails (R3 R4 R5 R6 R7).
        for (int p = 0; p < 256; p++) begin
            run_block({4'b1111, tails[p % 4], 8'(p)}, make_ext(32'(p)), "sweep");
        end
        // Pseudo-random full blocks.
        for (int k = 0; k < 400; k++) begin
            rng = next_rng(rng);
            hA = {4'b1111, rng[27:0]};
            run_block(hA, make_ext(rng), "random");
        end
        // Directed: long of exactly 6 extents, 7 extents, start in the last slot.
        run_block({4'b1111, 16'h0000, 12'b11_11_11_11_11_10}, make_ext(1), "R7 len6");
        run_block({4'b1111, 14'h0000, 14'b11_11_11_11_11_11_10}, make_ext(2), "R7 len7");
        run_block({4'b1111, 2'b10, 26'h0}, make_ext(3), "R7 last slot");
        run_block({4'b1111, 28'hFFFFFFF}, make_ext(4), "R6 all pimm");
        run_block({4'b1110, 28'h5A5A5A5}, make_ext(5), "R1 bad code E");
        run_block({4'b0000, 28'h0000000}, make_ext(6), "R1 bad code 0");

        // Back-pressure (R9).
        hA = {4'b1111, 28'h2B3C4D1};
        hB = {4'b1111, 28'h1E0F263};
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_hdr = hA; in_ext = make_ext(7);
        @(negedge clk);
        in_hdr = hB; in_ext = make_ext(8);
        chk("R9", "stall in_ready", 256'(in_ready), 256'(0));
        model(hA, make_ext(7));
        cmp_all("R9 stall first");
        @(negedge clk);
        chk("R9", "stall valid", 256'(out_valid), 256'(1));
        cmp_all("R9 stall held");
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(hB, make_ext(8));
        cmp_all("R9 drain and fill");
        @(negedge clk);
        chk("R9", "drained valid", 256'(out_valid), 256'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule